// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Reader

This block is the readout side of a configuration store that streams a bitstream into a programmable logic device. It holds a byte array of parameterised depth and a read position. On every rising clock edge while it is selected, it places the next item on its data pins: one bit per clock in serial mode, one byte per clock in parallel mode. The receiving device samples each item on the following rising edge.

Several readers can share one clock and one data bus. A reader drives the bus only while it is presenting its own contents. Once its last location has been presented, it releases the bus and raises a cascade output. That output feeds the select input of the next reader, so the chain reads out as one continuous stream. Extra clocks after the end, such as those from a free-running oscillator in parallel mode, do nothing: the reader stays finished until a reset.

The data pins are modelled at the core boundary as a value bus plus a per-bit drive enable, which the pad ring turns into a three-state pin. The array contents are written through a plain initialisation write port.

Top module: `cfg_stream_reader`

## Requirements
- R1: In parallel mode (`par_mode`=1), each rising edge with `sel`=1 presents the next stored byte on `dout[7:0]` with `dout_en`=8'hFF. Bytes come in address order, and location 0 appears after the first selected edge.
- R2: In serial mode (`par_mode`=0), each selected edge presents one bit on `dout[0]` with `dout_en`=8'h01. Each byte is sent most significant bit first, and the position moves to the next byte after eight edges.
- R3: A rising edge with `sel`=0 or `rst`=1 releases the bus (`dout_en`=0) and returns the read position to location 0, so the next selected readout starts again at location 0, bit 7.
- R4: `cascade` rises on the edge after the one that presented the last item (byte DEPTH-1, or bit 0 of byte DEPTH-1). It then stays high through any number of clocks with `sel` at either value, until `rst`.
- R5: After the last item the position does not wrap: every later edge leaves `dout_en`=0.
- R6: A rising edge with `rst`=1 clears `cascade`.
- R7: A rising edge with `init_we`=1 stores `init_data` at location `init_addr`. Readout then returns the written value.
- R8: Whenever `dout_en` is 0, `dout` reads 0. In serial mode, `dout[7:1]` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst | input | 1 | Synchronous output-enable/reset, active high |
| sel | input | 1 | Chip select, active high; driven by the previous reader's cascade |
| par_mode | input | 1 | 1 = byte-wide output, 0 = bit-serial output |
| init_we | input | 1 | Initialisation write strobe |
| init_addr | input | $clog2(DEPTH) | Initialisation write address |
| init_data | input | 8 | Initialisation write data |
| dout | output | 8 | Data bus value |
| dout_en | output | 8 | Per-bit pad drive enable |
| cascade | output | 1 | Select for the next reader in the chain |

## Verification
A read position that skips or repeats shows up at the pins on the very next selected clock: the byte or bit presented no longer matches the stored contents at the expected index. A wrong byte-boundary count in serial mode shows within eight clocks as a bit taken from the wrong byte. A done flag that is set early, late or not at all shows on the cascade pin, and also as a drive enable that is high when it should be low (or the reverse), on the clock right after the last item. A done flag that clears without a reset shows as the bus being driven again while a neighbour owns it.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } out_mode_e;

    // registered pin-side state
    typedef struct packed {
        logic  valid;
        logic  serial;
        byte_t data;
    } pin_state_t;

    // pick one bit of a byte, index 0 addressing the MSB
    function automatic logic msb_first_bit(byte_t b, logic [2:0] idx);
        return b[3'd7 - idx];
    endfunction

    function automatic byte_t enable_mask(pin_state_t s);
        if (!s.valid)
            return '0;
        else if (s.serial)
            return byte_t'(1);
        else
            return '1;
    endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  cfg_stream_pkg::byte_t       wr_data,
    input  logic [AW-1:0]               rd_addr,
    output cfg_stream_pkg::byte_t       rd_data
);
    import cfg_stream_pkg::*;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq #(
    parameter int DEPTH = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int PW  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sel,
    input  cfg_stream_pkg::out_mode_e   mode,
    output logic [AW-1:0]               rd_addr,
    output logic [2:0]                  bit_idx,
    output logic                        present,
    output logic                        done
);
    import cfg_stream_pkg::*;

    localparam logic [PW-1:0] END_POS = PW'(DEPTH);

    logic [PW-1:0] pos_q;
    logic [2:0]    bit_q;
    logic          done_q;
    logic          at_end;

    assign at_end  = (pos_q == END_POS);
    assign present = sel && !rst && !done_q && !at_end;
    assign rd_addr = pos_q[AW-1:0];
    assign bit_idx = bit_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            bit_q  <= '0;
            done_q <= 1'b0;
        end else if (!sel) begin
            pos_q  <= '0;
            bit_q  <= '0;
        end else if (present) begin
            if (mode == MODE_PARALLEL || bit_q == 3'd7) begin
                pos_q <= pos_q + 1'b1;
                bit_q <= '0;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else if (!done_q && at_end) begin
            done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_pin_stage.sv
module cfg_pin_stage (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        present,
    input  cfg_stream_pkg::out_mode_e   mode,
    input  cfg_stream_pkg::byte_t       rd_byte,
    input  logic [2:0]                  bit_idx,
    output cfg_stream_pkg::byte_t       pin_data,
    output cfg_stream_pkg::byte_t       pin_en
);
    import cfg_stream_pkg::*;

    pin_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.valid  <= present;
            st_q.serial <= (mode == MODE_SERIAL);
            if (!present)
                st_q.data <= '0;
            else if (mode == MODE_PARALLEL)
                st_q.data <= rd_byte;
            else
                st_q.data <= byte_t'(msb_first_bit(rd_byte, bit_idx));
        end
    end

    assign pin_data = st_q.valid ? st_q.data : '0;
    assign pin_en   = enable_mask(st_q);

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          par_mode,
    input  logic          init_we,
    input  logic [AW-1:0] init_addr,
    input  logic [7:0]    init_data,
    output logic [7:0]    dout,
    output logic [7:0]    dout_en,
    output logic          cascade
);
    import cfg_stream_pkg::*;

    out_mode_e     mode;
    logic [AW-1:0] rd_addr;
    logic [2:0]    bit_idx;
    logic          present;
    byte_t         rd_byte;

    assign mode = par_mode ? MODE_PARALLEL : MODE_SERIAL;

    cfg_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (init_we),
        .wr_addr (init_addr),
        .wr_data (init_data),
        .rd_addr (rd_addr),
        .rd_data (rd_byte)
    );

    cfg_seq #(.DEPTH(DEPTH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .mode    (mode),
        .rd_addr (rd_addr),
        .bit_idx (bit_idx),
        .present (present),
        .done    (cascade)
    );

    cfg_pin_stage u_pins (
        .clk      (clk),
        .rst      (rst),
        .present  (present),
        .mode     (mode),
        .rd_byte  (rd_byte),
        .bit_idx  (bit_idx),
        .pin_data (dout),
        .pin_en   (dout_en)
    );

endmodule

// File: rtl/cfg_stream_checker.sv
module cfg_stream_checker (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       par_mode,
    input logic [7:0] dout,
    input logic [7:0] dout_en,
    input logic       cascade
);
    AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !sel |=> dout_en == 8'h00); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!cascade && dout_en == 8'h00)); // R6

    AST_CASCADE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cascade |=> cascade); // R4

    AST_RELEASED_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        cascade |-> dout_en == 8'h00); // R5

    AST_CASCADE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(cascade) |-> $past(dout_en) != 8'h00); // R4

    AST_MODE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (sel && dout_en != 8'h00) |-> (dout_en == (par_mode ? 8'hFF : 8'h01) || !$stable(par_mode))); // R1 R2

    AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk)
        (dout_en == 8'h00) |-> (dout == 8'h00)); // R8

    AST_SERIAL_UPPER_ZERO: assert property (@(posedge clk)
        (dout_en == 8'h01) |-> (dout[7:1] == 7'd0)); // R8
endmodule

bind cfg_stream_reader cfg_stream_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .par_mode (par_mode),
    .dout     (dout),
    .dout_en  (dout_en),
    .cascade  (cascade)
);

// File: tb/sim_cfg_stream_reader.sv
`timescale 1ns/1ps
module sim_cfg_stream_reader;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          par_mode = 1'b1;
    logic          init_we = 1'b0;
    logic [AW-1:0] init_addr = '0;
    logic [7:0]    init_data = '0;
    logic [7:0]    dout, dout_en;
    logic          cascade;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] img [DEPTH];

    always #2.5 clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .sel(sel), .par_mode(par_mode),
        .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
        .dout(dout), .dout_en(dout_en), .cascade(cascade)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] exp_item(bit par, int i);
        if (par) return img[i];
        return {7'd0, img[i/8][7 - (i%8)]};
    endfunction

    function automatic logic [7:0] exp_mask(bit par);
        return par ? 8'hFF : 8'h01;
    endfunction

    task automatic do_reset();
        rst = 1'b1; sel = 1'b0;
        step();
        rst = 1'b0;
    endtask

    // expects position 0 at start; checks n selected edges
    task automatic run_stream(input bit par, input int n, input string tag);
        int total = par ? DEPTH : 8 * DEPTH;
        par_mode = par; sel = 1'b1;
        for (int i = 0; i < n; i++) begin
            step();
            if (i < total) begin
                chk(dout === exp_item(par, i), tag, dout, exp_item(par, i));
                chk(dout_en === exp_mask(par), tag, dout_en, exp_mask(par));
                chk(cascade === 1'b0, {tag, " R4 early"}, cascade, 0);
            end else begin
                chk(dout_en === 8'h00 && dout === 8'h00, {tag, " R5 R8"}, dout_en, 0);
                chk(cascade === 1'b1, {tag, " R4"}, cascade, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R6 R3: reset state
        step();
        chk(dout_en === 8'h00, "R3 reset en", dout_en, 0);
        chk(cascade === 1'b0, "R6 reset cascade", cascade, 0);
        chk(dout === 8'h00, "R8 reset data", dout, 0);

        // R7: load image
        for (int a = 0; a < DEPTH; a++) begin
            img[a] = 8'($urandom);
            init_we = 1'b1; init_addr = AW'(a); init_data = img[a];
            step();
        end
        img[0] = 8'hA5; init_addr = '0; init_data = 8'hA5;
        step();
        init_we = 1'b0;
        do_reset();

        // R1 R5 R7: parallel full readout plus free-running clocks
        run_stream(1'b1, DEPTH + 20, "R1 par");

        // R4: deselect does not clear cascade
        sel = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(cascade === 1'b1, "R4 sticky", cascade, 1);
            chk(dout_en === 8'h00, "R3 desel", dout_en, 0);
        end
        // R6
        rst = 1'b1; step();
        chk(cascade === 1'b0, "R6 clear", cascade, 0);
        rst = 1'b0;

        // R3: partial serial, deselect, restart from bit 7 of location 0
        run_stream(1'b0, 11, "R2 ser part");
        sel = 1'b0; step();
        chk(dout_en === 8'h00, "R3 desel mid", dout_en, 0);
        run_stream(1'b0, 8 * DEPTH + 4, "R2 ser full");

        // R3: reset mid parallel stream restarts at 0
        do_reset();
        run_stream(1'b1, 5, "R1 part");
        rst = 1'b1; step();
        chk(dout_en === 8'h00, "R3 rst mid", dout_en, 0);
        rst = 1'b0;
        run_stream(1'b1, 3, "R3 restart");

        // random rounds
        for (int r = 0; r < 30; r++) begin
            bit par = 1'($urandom);
            int tot = par ? DEPTH : 8 * DEPTH;
            do_reset();
            if ($urandom % 3 == 0) begin
                int a = int'($urandom % DEPTH);
                img[a] = 8'($urandom);
                init_we = 1'b1; init_addr = AW'(a); init_data = img[a];
                step();
                init_we = 1'b0;
                do_reset();
            end
            run_stream(par, int'($urandom % (tot + 6)) + 1, par ? "R1 rnd" : "R2 rnd");
        end

        sel = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule